// File: doc/BRIEF.md
# Multichannel DAC Gain-Offset Correction Engine

This block is the digital trim front end of a 32-channel, 14-bit voltage DAC. A parallel write port carries a channel number, a two-bit target select and a 14-bit data word. Every channel keeps three registers: an input code, a gain coefficient and an offset coefficient. When any of them is written, one shared correction unit recomputes that channel's trimmed code and stores it in a pending stage. The unit scales the input by the gain plus two, divides by 2^14, adds the offset less mid-scale, and clamps the result.

The outputs are double buffered. A single load strobe copies the pending codes of all channels into the DAC output registers on the same clock edge, so every analog output can change together. Writes with the special-function select change no channel register. They produce a one-cycle strobe that passes the address and data on to logic outside the block.

Top module: `dac_trim_engine`

## Requirements
- R1: The select field `wr_sel` picks the target of a write: 2'b11 the input code x1, 2'b10 the offset c, 2'b01 the gain m, and 2'b00 the special-function path.
- R2: After reset every gain register holds 0x3FFE and every offset register holds 0x2000. Every input code, pending code and DAC code is 0, and `sfr_strobe` is low.
- R3: On the clock edge that accepts a write with select 2'b01, 2'b10 or 2'b11, the addressed channel's pending code becomes floor((m+2)·x1 / 2^14) + c − 8192. The newly written value is used in place of the old one.
- R4: Bit 0 of a gain register is always stored as 0, whatever the value of `wr_data[0]`.
- R5: The corrected code is clamped to the range 0 to 16383. It never wraps.
- R6: The 32 channels are independent. A write changes only the pending code of the channel named by `wr_chan`.
- R7: On an edge where `load` is high, every channel's DAC code takes that channel's pending code. On any other edge, all DAC codes hold their values.
- R8: When a write and `load` occur in the same cycle, the DAC codes take the pending codes as they were before that write.
- R9: A write with select 2'b00 raises `sfr_strobe` for exactly the following cycle, with `sfr_addr` and `sfr_data` equal to the written channel and data. It changes no pending or DAC code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Single-cycle write strobe |
| wr_chan | input | 5 | Channel number of the write |
| wr_sel | input | 2 | Target select (R1 encoding) |
| wr_data | input | 14 | Write data |
| load | input | 1 | Global transfer of pending codes to DAC codes |
| sfr_strobe | output | 1 | Special-function write seen, one cycle |
| sfr_addr | output | 5 | Channel field of the special-function write |
| sfr_data | output | 14 | Data of the special-function write |
| dac_codes | output | 448 | DAC codes, channel k in bits [14k+13:14k] |

## Verification
The two functions that can fall on the same edge are the recomputation of a pending code after a write and the global load. They are provoked together on purpose: a directed case writes a new input code while `load` is high, and a random phase asserts both strobes independently every cycle. They are judged against a behavioural model in the bench that applies the load from the old pending values before it applies the write. The directed case expects the DAC to show the previous code until a later load.

// File: rtl/trim_pkg.sv
package trim_pkg;
   typedef enum logic [1:0] {
      SEL_SFR  = 2'b00,
      SEL_GAIN = 2'b01,
      SEL_OFFS = 2'b10,
      SEL_CODE = 2'b11
   } trim_sel_e;
endpackage

// File: rtl/trim_regfile.sv
module trim_regfile
   import trim_pkg::*;
#(
   parameter int NCH = 32,
   parameter int DW  = 14,
   parameter int AW  = $clog2(NCH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    sel,
   input  logic [AW-1:0] chan,
   input  logic [DW-1:0] data,
   output logic [DW-1:0] rd_x1,
   output logic [DW-1:0] rd_m,
   output logic [DW-1:0] rd_c
);
   localparam logic [DW-1:0] GAIN_RST = {{(DW-1){1'b1}}, 1'b0};
   localparam logic [DW-1:0] OFFS_RST = {1'b1, {(DW-1){1'b0}}};

   logic [DW-1:0] x1_q [NCH];
   logic [DW-1:0] m_q  [NCH];
   logic [DW-1:0] c_q  [NCH];

   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic hit;
      assign hit = we && (chan == AW'(k));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            x1_q[k] <= '0;
            m_q[k]  <= GAIN_RST;
            c_q[k]  <= OFFS_RST;
         end else if (hit) begin
            case (trim_sel_e'(sel))
               SEL_CODE: x1_q[k] <= data;
               SEL_OFFS: c_q[k]  <= data;
               SEL_GAIN: m_q[k]  <= {data[DW-1:1], 1'b0};
               default:  ;
            endcase
         end
      end
   end

   assign rd_x1 = x1_q[chan];
   assign rd_m  = m_q[chan];
   assign rd_c  = c_q[chan];
endmodule

// File: rtl/trim_calc.sv
module trim_calc #(
   parameter int DW = 14
) (
   input  logic [DW-1:0] x1,
   input  logic [DW-1:0] m,
   input  logic [DW-1:0] c,
   output logic [DW-1:0] code
);
   localparam int PW = 2*DW + 1;
   localparam int SW = PW + 2;
   localparam logic signed [SW-1:0] HALF = SW'(1) << (DW-1);
   localparam logic signed [SW-1:0] TOP  = {{(SW-DW){1'b0}}, {DW{1'b1}}};

   logic [PW-1:0]        prod;
   logic [PW-1:0]        scaled;
   logic signed [SW-1:0] sum;

   always_comb begin
      prod   = (PW'(m) + PW'(2)) * PW'(x1);
      scaled = prod >> DW;
      sum    = $signed({2'b00, scaled}) + $signed({{(SW-DW){1'b0}}, c}) - HALF;
      if (sum < 0)
         code = '0;
      else if (sum > TOP)
         code = '1;
      else
         code = sum[DW-1:0];
   end
endmodule

// File: rtl/trim_dbuf.sv
module trim_dbuf #(
   parameter int NCH = 32,
   parameter int DW  = 14,
   parameter int AW  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [AW-1:0]     upd_chan,
   input  logic [DW-1:0]     upd_code,
   input  logic              load,
   output logic [NCH*DW-1:0] pend_flat,
   output logic [NCH*DW-1:0] dac_flat
);
   for (genvar k = 0; k < NCH; k++) begin : g_ch
      logic [DW-1:0] pend_q, dac_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= '0;
            dac_q  <= '0;
         end else begin
            if (upd && (upd_chan == AW'(k))) pend_q <= upd_code;
            if (load) dac_q <= pend_q;
         end
      end
      assign pend_flat[k*DW +: DW] = pend_q;
      assign dac_flat[k*DW +: DW]  = dac_q;
   end
endmodule

// File: rtl/dac_trim_engine.sv
module dac_trim_engine
   import trim_pkg::*;
#(
   parameter int NCH = 32,
   parameter int DW  = 14,
   parameter int AW  = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [AW-1:0]     wr_chan,
   input  logic [1:0]        wr_sel,
   input  logic [DW-1:0]     wr_data,
   input  logic              load,
   output logic              sfr_strobe,
   output logic [AW-1:0]     sfr_addr,
   output logic [DW-1:0]     sfr_data,
   output logic [NCH*DW-1:0] dac_codes
);
   if (DW < 4) begin : g_bad_dw
      $error("trim engine: DW must be at least 4");
   end
   if (NCH < 2 || NCH > (1 << AW)) begin : g_bad_nch
      $error("trim engine: NCH must fit the address width");
   end

   logic              chan_wr;
   logic              sfr_wr;
   logic [DW-1:0]     rd_x1, rd_m, rd_c;
   logic [DW-1:0]     op_x1, op_m, op_c;
   logic [DW-1:0]     new_code;
   logic [NCH*DW-1:0] pend_flat;

   assign sfr_wr  = wr_valid && (trim_sel_e'(wr_sel) == SEL_SFR);
   assign chan_wr = wr_valid && !sfr_wr;

   trim_regfile #(.NCH(NCH), .DW(DW), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(chan_wr), .sel(wr_sel),
      .chan(wr_chan), .data(wr_data),
      .rd_x1(rd_x1), .rd_m(rd_m), .rd_c(rd_c)
   );

   // forward the word being written into the correction operands
   always_comb begin
      op_x1 = rd_x1;
      op_m  = rd_m;
      op_c  = rd_c;
      case (trim_sel_e'(wr_sel))
         SEL_CODE: op_x1 = wr_data;
         SEL_OFFS: op_c  = wr_data;
         SEL_GAIN: op_m  = {wr_data[DW-1:1], 1'b0};
         default:  ;
      endcase
   end

   trim_calc #(.DW(DW)) u_calc (
      .x1(op_x1), .m(op_m), .c(op_c), .code(new_code)
   );

   trim_dbuf #(.NCH(NCH), .DW(DW), .AW(AW)) u_dbuf (
      .clk(clk), .rst_n(rst_n), .upd(chan_wr), .upd_chan(wr_chan),
      .upd_code(new_code), .load(load),
      .pend_flat(pend_flat), .dac_flat(dac_codes)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sfr_strobe <= 1'b0;
         sfr_addr   <= '0;
         sfr_data   <= '0;
      end else begin
         sfr_strobe <= sfr_wr;
         if (sfr_wr) begin
            sfr_addr <= wr_chan;
            sfr_data <= wr_data;
         end
      end
   end
endmodule

// File: rtl/trim_chk.sv
module trim_chk #(
   parameter int NCH = 32,
   parameter int DW  = 14,
   parameter int AW  = $clog2(NCH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [AW-1:0]     wr_chan,
   input logic [1:0]        wr_sel,
   input logic [DW-1:0]     wr_data,
   input logic              load,
   input logic              sfr_strobe,
   input logic [AW-1:0]     sfr_addr,
   input logic [DW-1:0]     sfr_data,
   input logic [NCH*DW-1:0] pend_flat,
   input logic [NCH*DW-1:0] dac_codes
);
   a_r9_sfr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_sel == 2'b00) |=>
         (sfr_strobe && sfr_addr == $past(wr_chan) && sfr_data == $past(wr_data)));

   a_r9_sfr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_valid && wr_sel == 2'b00) |=> !sfr_strobe);

   a_r9_sfr_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_sel == 2'b00) |=> $stable(pend_flat));

   a_r6_idle_pend: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |=> $stable(pend_flat));

   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(dac_codes));

   a_r8_load_old: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dac_codes == $past(pend_flat)));
endmodule

bind dac_trim_engine trim_chk #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
   .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
   .sfr_strobe(sfr_strobe), .sfr_addr(sfr_addr), .sfr_data(sfr_data),
   .pend_flat(pend_flat), .dac_codes(dac_codes)
);

// File: tb/tb_dac_trim_engine.sv
module tb_dac_trim_engine;
   localparam int NCH = 32;
   localparam int DW  = 14;
   localparam int AW  = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_valid = 1'b0;
   logic [AW-1:0]     wr_chan = '0;
   logic [1:0]        wr_sel = '0;
   logic [DW-1:0]     wr_data = '0;
   logic              load = 1'b0;
   logic              sfr_strobe;
   logic [AW-1:0]     sfr_addr;
   logic [DW-1:0]     sfr_data;
   logic [NCH*DW-1:0] dac_codes;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int mx1 [NCH];
   int mm  [NCH];
   int mc  [NCH];
   int mp  [NCH];
   int md  [NCH];
   int m_sfr, m_sfr_a, m_sfr_d;

   dac_trim_engine dut (
      .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan),
      .wr_sel(wr_sel), .wr_data(wr_data), .load(load),
      .sfr_strobe(sfr_strobe), .sfr_addr(sfr_addr), .sfr_data(sfr_data),
      .dac_codes(dac_codes)
   );

   always #5 clk = ~clk;

   function automatic int trim(input int x, input int g, input int o);
      int v;
      v = (((g + 2) * x) >>> 14) + o - 8192;
      if (v < 0) v = 0;
      if (v > 16383) v = 16383;
      return v;
   endfunction

   function automatic int code_of(input int ch);
      return int'(dac_codes[ch*DW +: DW]);
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // behavioural reference, stepped on each clock and compared after it
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < NCH; k++) begin
            mx1[k] = 0; mm[k] = 16382; mc[k] = 8192; mp[k] = 0; md[k] = 0;
         end
         m_sfr = 0; m_sfr_a = 0; m_sfr_d = 0;
      end else begin
         if (load)
            for (int k = 0; k < NCH; k++) md[k] = mp[k];
         m_sfr = 0;
         if (wr_valid) begin
            case (wr_sel)
               2'b11: mx1[wr_chan] = int'(wr_data);
               2'b10: mc[wr_chan]  = int'(wr_data);
               2'b01: mm[wr_chan]  = int'(wr_data) & 16382;
               default: begin
                  m_sfr = 1; m_sfr_a = int'(wr_chan); m_sfr_d = int'(wr_data);
               end
            endcase
            if (wr_sel != 2'b00)
               mp[wr_chan] = trim(mx1[wr_chan], mm[wr_chan], mc[wr_chan]);
         end
         #1;
         for (int k = 0; k < NCH; k++)
            check("R3 R7 model", code_of(k), md[k]);
         check("R9 model strobe", int'(sfr_strobe), m_sfr);
         if (m_sfr == 1) begin
            check("R9 model addr", int'(sfr_addr), m_sfr_a);
            check("R9 model data", int'(sfr_data), m_sfr_d);
         end
      end
   end

   task automatic wr(input int ch, input int sel, input int data, input bit ld);
      @(negedge clk);
      wr_valid = 1'b1; wr_chan = AW'(ch); wr_sel = 2'(sel); wr_data = DW'(data);
      load = ld;
      @(negedge clk);
      wr_valid = 1'b0; load = 1'b0;
   endtask

   task automatic do_load();
      @(negedge clk);
      load = 1'b1;
      @(negedge clk);
      load = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 reset dac ch0", code_of(0), 0);
      check("R2 reset strobe", int'(sfr_strobe), 0);
      do_load();
      check("R2 default trim of zero", code_of(31), 0);

      wr(3, 3, 1000, 0);
      check("R7 no load keeps dac", code_of(3), 0);
      do_load();
      check("R3 default gain passes code", code_of(3), 1000);

      wr(10, 2, 16'h2005, 0);
      wr(10, 3, 100, 0);
      do_load();
      check("R3 offset plus five", code_of(10), 105);

      wr(5, 1, 16'h2001, 0);
      wr(5, 3, 16'h3FFF, 0);
      do_load();
      check("R4 gain lsb dropped", code_of(5), 8193);

      wr(7, 2, 16'h3FFF, 0);
      wr(7, 3, 16'h3FFF, 0);
      do_load();
      check("R5 clamp high", code_of(7), 16383);
      wr(8, 2, 0, 0);
      wr(8, 3, 10, 0);
      do_load();
      check("R5 clamp low", code_of(8), 0);
      check("R6 other channel untouched", code_of(4), 0);
      check("R6 earlier channel kept", code_of(3), 1000);

      wr(3, 3, 2000, 1);
      check("R8 same-cycle load takes old", code_of(3), 1000);
      do_load();
      check("R8 later load takes new", code_of(3), 2000);

      wr(9, 0, 16'h0155, 0);
      check("R9 strobe high", int'(sfr_strobe), 1);
      check("R9 addr", int'(sfr_addr), 9);
      check("R9 data", int'(sfr_data), 16'h0155);
      check("R1 sfr select not code", code_of(9), 0);
      @(negedge clk);
      check("R9 strobe single cycle", int'(sfr_strobe), 0);
      do_load();
      check("R9 no channel change", code_of(9), 0);

      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         wr_valid = ($urandom_range(0, 3) != 0);
         wr_chan  = AW'($urandom_range(0, NCH-1));
         wr_sel   = 2'($urandom_range(0, 3));
         wr_data  = DW'($urandom_range(0, 16383));
         load     = ($urandom_range(0, 2) == 0);
      end
      @(negedge clk);
      wr_valid = 1'b0; load = 1'b0;
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule